// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a stream of asynchronous serial characters on one data line into parallel bytes held for a host register interface. Bit timing comes from an external receive clock that is synchronised into the system clock domain. Each rising edge of that clock becomes a one-cycle tick. A 2-bit rate code makes the receiver sample once per tick (x1), or once every `SLOW_DIV` or `SLOWER_DIV` ticks, with the start bit confirmed half a bit into the frame. A 3-bit format code picks the data length, the parity kind and the stop-bit count.

A finished character moves into a holding register, and the register interface sees it there. The interface then sees a full flag, a framing-error flag, a parity-error flag and an overrun flag. The interface returns a one-cycle read strobe whenever it consumes the data. If a character arrives while the register is still unread, the new character is dropped. The overrun is then held back until the earlier character has been read, and the full flag stays set throughout. A carrier-lost input masks the full flag for as long as it is high. Rate code 11 holds the whole receiver in master reset.

The bit-level state machine has six states. IDLE moves to START on a low sample, or straight to DATA in x1 mode. START goes back to IDLE when the line is high again at mid-bit (a glitch), and moves on to DATA when the line is still low. DATA moves to PARITY after the last data bit when parity is on, and to STOP1 otherwise. PARITY moves to STOP1. STOP1 transfers the character and moves to STOP2 in two-stop formats, and to IDLE otherwise. STOP2 waits out one bit time and then moves to IDLE. Master reset sends every state to IDLE.

Top module: `async_rx`

## Requirements
- R1: After reset, `rx_full`, `frame_err`, `par_err` and `overrun` are 0 and `rx_data` is 0x00.
- R2: The format code `word_sel` selects the frame as follows. 000 is 7 data bits, even parity, 2 stop bits. 001 is 7 bits, odd parity, 2 stop. 010 is 7 bits, even parity, 1 stop. 011 is 7 bits, odd parity, 1 stop. 100 is 8 bits, no parity, 2 stop. 101 is 8 bits, no parity, 1 stop. 110 is 8 bits, even parity, 1 stop. 111 is 8 bits, odd parity, 1 stop. A correctly framed character in any format raises `rx_full` with its data.
- R3: Data bits arrive LSB first. In the 7-bit formats, `rx_data[7]` reads 0.
- R4: Rate code `div_sel` 00 samples every rising receive-clock edge. Code 01 samples once per 16 edges and code 10 once per 64 edges, each at mid-bit.
- R5: In the /16 and /64 rates, a low level on `rxd` that has ended by the middle of the start bit is ignored, and `rx_full` stays 0.
- R6: `frame_err` is 1 when the first stop bit is sampled low. It is loaded with the character and stays valid while that character is held.
- R7: `par_err` is 1 when the total count of ones in the data and parity bits is odd for even parity, or even for odd parity. It is always 0 in the no-parity formats.
- R8: If a second character completes while `rx_full` is set, the stored data is kept and `overrun` stays 0. The first read strobe then raises `overrun` and leaves `rx_full` at 1. A second read strobe clears both flags.
- R9: A read strobe with no pending overrun clears `rx_full`, `frame_err` and `par_err` on the next cycle.
- R10: While `carrier_lost` is 1, `rx_full` reads 0. The stored character and flag return unchanged when `carrier_lost` goes back to 0.
- R11: `div_sel` = 11 clears every flag and `rx_data`, and it ignores line activity. Reception resumes once a valid rate code is restored.
- R12: Character framing stays in step through an overrun: the next character after the overrun is cleared is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial data line, idle high |
| rxc | input | 1 | External receive clock, sampled on its rising edge |
| div_sel | input | 2 | Rate code: 00 x1, 01 /16, 10 /64, 11 master reset |
| word_sel | input | 3 | Frame format code |
| rd_stb | input | 1 | One-cycle strobe: the holding register was read |
| carrier_lost | input | 1 | High when no carrier is present; masks the full flag |
| rx_data | output | 8 | Received character |
| rx_full | output | 1 | Holding register holds an unread character |
| frame_err | output | 1 | Stop bit of the held character was low |
| par_err | output | 1 | Parity of the held character was wrong |
| overrun | output | 1 | One or more characters were lost |

## Verification
The bench builds the receiver with its default parameters: `SLOW_DIV` = 16, `SLOWER_DIV` = 64 and two synchroniser stages. It drives the receive clock at one quarter of the system clock rate. With these values all three rates can be run within a short run: every format code at x1, the glitch and error cases at /16, and one full character at /64. The two-stage synchroniser places the sample points a fixed few cycles behind the receive-clock edges, so the overrun and master-reset sequences can be checked at exact read boundaries.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int CHAR_W = 8;

    localparam logic [1:0] RATE_X1  = 2'b00;
    localparam logic [1:0] RATE_LO  = 2'b01;
    localparam logic [1:0] RATE_HI  = 2'b10;
    localparam logic [1:0] RATE_RST = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic eight_bits;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              frame_err;
        logic              par_err;
    } rx_char_t;

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_in,
    input  logic rxc_in,
    output logic rxd_s,
    output logic tick
);

    logic [STAGES-1:0] d_q;
    logic [STAGES-1:0] c_q;
    logic              c_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q    <= '1;
            c_q    <= '0;
            c_last <= 1'b0;
        end else begin
            d_q    <= {d_q[STAGES-2:0], rxd_in};
            c_q    <= {c_q[STAGES-2:0], rxc_in};
            c_last <= c_q[STAGES-1];
        end
    end

    assign rxd_s = d_q[STAGES-1];
    assign tick  = c_q[STAGES-1] & ~c_last;

endmodule

// File: rtl/arx_frame_decode.sv
module arx_frame_decode
    import arx_pkg::*;
(
    input  logic [2:0]  word_sel,
    output frame_cfg_t  cfg
);

    always_comb begin
        cfg = '0;
        unique case (word_sel)
            3'b000: cfg = '{eight_bits: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b1};
            3'b001: cfg = '{eight_bits: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b1};
            3'b010: cfg = '{eight_bits: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
            3'b011: cfg = '{eight_bits: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
            3'b100: cfg = '{eight_bits: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b1};
            3'b101: cfg = '{eight_bits: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b0};
            3'b110: cfg = '{eight_bits: 1'b1, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
            3'b111: cfg = '{eight_bits: 1'b1, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
            default: cfg = '0;
        endcase
    end

endmodule

// File: rtl/arx_bit_fsm.sv
module arx_bit_fsm
    import arx_pkg::*;
#(
    parameter int SLOW_DIV   = 16,
    parameter int SLOWER_DIV = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold,
    input  logic        tick,
    input  logic        rxd,
    input  logic [1:0]  div_sel,
    input  frame_cfg_t  cfg,
    output logic        done,
    output rx_char_t    chr
);

    localparam int PH_W = $clog2(SLOWER_DIV);

    rx_state_e          state, state_n;
    logic [PH_W-1:0]    ph;
    logic [PH_W-1:0]    bit_last;
    logic [PH_W-1:0]    half_last;
    logic [2:0]         bit_cnt;
    logic [2:0]         last_data;
    logic [CHAR_W-1:0]  sr;
    logic               par_acc;
    logic               pe_q;
    logic               at_bit;

    // rate decode: phase count at which a bit is sampled
    always_comb begin
        bit_last  = '0;
        half_last = '0;
        unique case (div_sel)
            RATE_X1: begin
                bit_last  = '0;
                half_last = '0;
            end
            RATE_LO: begin
                bit_last  = PH_W'(SLOW_DIV - 1);
                half_last = PH_W'(SLOW_DIV / 2 - 1);
            end
            default: begin
                bit_last  = PH_W'(SLOWER_DIV - 1);
                half_last = PH_W'(SLOWER_DIV / 2 - 1);
            end
        endcase
    end

    assign at_bit    = (ph == bit_last);
    assign last_data = cfg.eight_bits ? 3'd7 : 3'd6;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (hold) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (!rxd) begin
                        state_n = (div_sel == RATE_X1) ? ST_DATA : ST_START;
                    end
                end
                ST_START: begin
                    if (ph == half_last) begin
                        state_n = rxd ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (at_bit && (bit_cnt == last_data)) begin
                        state_n = cfg.par_en ? ST_PARITY : ST_STOP1;
                    end
                end
                ST_PARITY: begin
                    if (at_bit) begin
                        state_n = ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (at_bit) begin
                        state_n = cfg.two_stop ? ST_STOP2 : ST_IDLE;
                    end
                end
                ST_STOP2: begin
                    if (at_bit) begin
                        state_n = ST_IDLE;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= '0;
            bit_cnt <= '0;
            sr      <= '0;
            par_acc <= 1'b0;
            pe_q    <= 1'b0;
            done    <= 1'b0;
            chr     <= '0;
        end else if (hold) begin
            ph      <= '0;
            bit_cnt <= '0;
            sr      <= '0;
            par_acc <= 1'b0;
            pe_q    <= 1'b0;
            done    <= 1'b0;
            chr     <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        ph      <= '0;
                        bit_cnt <= '0;
                        par_acc <= 1'b0;
                        pe_q    <= 1'b0;
                    end
                    ST_START: begin
                        ph <= (ph == half_last) ? '0 : ph + 1'b1;
                    end
                    ST_DATA: begin
                        ph <= at_bit ? '0 : ph + 1'b1;
                        if (at_bit) begin
                            sr      <= {rxd, sr[CHAR_W-1:1]};
                            par_acc <= par_acc ^ rxd;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_PARITY: begin
                        ph <= at_bit ? '0 : ph + 1'b1;
                        if (at_bit) begin
                            pe_q <= ((par_acc ^ rxd) != cfg.par_odd);
                        end
                    end
                    ST_STOP1: begin
                        ph <= at_bit ? '0 : ph + 1'b1;
                        if (at_bit) begin
                            done          <= 1'b1;
                            chr.data      <= cfg.eight_bits ? sr : {1'b0, sr[CHAR_W-1:1]};
                            chr.frame_err <= ~rxd;
                            chr.par_err   <= cfg.par_en & pe_q;
                        end
                    end
                    ST_STOP2: begin
                        ph <= at_bit ? '0 : ph + 1'b1;
                    end
                    default: ph <= '0;
                endcase
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n || hold)
        done |=> !done); // R4

    AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n || hold)
        $rose(done) |-> ($past(state) == ST_STOP1)); // R6

    AST_NOPAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (done && !cfg.par_en) |-> !chr.par_err); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state == ST_IDLE)); // R11

endmodule

// File: rtl/arx_holding.sv
module arx_holding
    import arx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              done,
    input  rx_char_t          chr,
    input  logic              rd_stb,
    output logic [CHAR_W-1:0] data_q,
    output logic              full_q,
    output logic              fe_q,
    output logic              pe_q,
    output logic              vis_q
);

    logic              pend_q;
    logic              full_n, pend_n, vis_n, fe_n, pe_n;
    logic [CHAR_W-1:0] data_n;

    always_comb begin
        full_n = full_q;
        pend_n = pend_q;
        vis_n  = vis_q;
        fe_n   = fe_q;
        pe_n   = pe_q;
        data_n = data_q;
        if (rd_stb) begin
            if (pend_q) begin
                pend_n = 1'b0;
                vis_n  = 1'b1;
            end else begin
                full_n = 1'b0;
                vis_n  = 1'b0;
                fe_n   = 1'b0;
                pe_n   = 1'b0;
            end
        end
        if (done) begin
            if (full_n) begin
                if (!vis_n) begin
                    pend_n = 1'b1;
                end
            end else begin
                full_n = 1'b1;
                data_n = chr.data;
                fe_n   = chr.frame_err;
                pe_n   = chr.par_err;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            pend_q <= 1'b0;
            vis_q  <= 1'b0;
            fe_q   <= 1'b0;
            pe_q   <= 1'b0;
            data_q <= '0;
        end else if (hold) begin
            full_q <= 1'b0;
            pend_q <= 1'b0;
            vis_q  <= 1'b0;
            fe_q   <= 1'b0;
            pe_q   <= 1'b0;
            data_q <= '0;
        end else begin
            full_q <= full_n;
            pend_q <= pend_n;
            vis_q  <= vis_n;
            fe_q   <= fe_n;
            pe_q   <= pe_n;
            data_q <= data_n;
        end
    end

    AST_OVR_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n || hold)
        vis_q |-> full_q); // R8

    AST_OVR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n || hold)
        $rose(vis_q) |-> $past(rd_stb)); // R8

    AST_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (full_q && done && !rd_stb) |=> $stable(data_q)); // R8

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (rd_stb && !pend_q && !done) |=> !full_q); // R9

    AST_DONE_FILLS: assert property (@(posedge clk) disable iff (!rst_n || hold)
        done |=> full_q); // R2

endmodule

// File: rtl/async_rx.sv
module async_rx
    import arx_pkg::*;
#(
    parameter int SLOW_DIV    = 16,
    parameter int SLOWER_DIV  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              rxc,
    input  logic [1:0]        div_sel,
    input  logic [2:0]        word_sel,
    input  logic              rd_stb,
    input  logic              carrier_lost,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_full,
    output logic              frame_err,
    output logic              par_err,
    output logic              overrun
);

    logic       hold;
    logic       rxd_s;
    logic       tick;
    logic       done;
    logic       full_raw;
    frame_cfg_t cfg;
    rx_char_t   chr;

    assign hold = (div_sel == RATE_RST);

    arx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rxd_in (rxd),
        .rxc_in (rxc),
        .rxd_s  (rxd_s),
        .tick   (tick)
    );

    arx_frame_decode u_dec (
        .word_sel (word_sel),
        .cfg      (cfg)
    );

    arx_bit_fsm #(.SLOW_DIV(SLOW_DIV), .SLOWER_DIV(SLOWER_DIV)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .tick    (tick),
        .rxd     (rxd_s),
        .div_sel (div_sel),
        .cfg     (cfg),
        .done    (done),
        .chr     (chr)
    );

    arx_holding u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .done   (done),
        .chr    (chr),
        .rd_stb (rd_stb),
        .data_q (rx_data),
        .full_q (full_raw),
        .fe_q   (frame_err),
        .pe_q   (par_err),
        .vis_q  (overrun)
    );

    assign rx_full = full_raw & ~carrier_lost;

    AST_SEVEN_BIT_MSB: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (full_raw && !cfg.eight_bits) |-> (rx_data[CHAR_W-1] == 1'b0)); // R3

endmodule

// File: tb/sim_async_rx.sv
module sim_async_rx;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       rxc = 1'b0;
    logic [1:0] div_sel = 2'b01;
    logic [2:0] word_sel = 3'b101;
    logic       rd_auto = 1'b0;
    logic       rd_man = 1'b0;
    logic       rd_stb;
    logic       carrier_lost = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, frame_err, par_err, overrun;

    int         n_chk = 0;
    int         n_bad = 0;
    int         ndiv = 16;
    bit         auto_rd = 1'b0;
    bit         finished = 1'b0;
    string      tag = "R2";
    logic [9:0] exp_q[$];

    assign rd_stb = rd_auto | rd_man;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_rx u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rxd          (rxd),
        .rxc          (rxc),
        .div_sel      (div_sel),
        .word_sel     (word_sel),
        .rd_stb       (rd_stb),
        .carrier_lost (carrier_lost),
        .rx_data      (rx_data),
        .rx_full      (rx_full),
        .frame_err    (frame_err),
        .par_err      (par_err),
        .overrun      (overrun)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rxc_cycle();
        rxc = 1'b0;
        repeat (2) @(negedge clk);
        rxc = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (ndiv) rxc_cycle();
    endtask

    task automatic send_char(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit push);
        bit         eight;
        bit         pen;
        bit         podd;
        bit         two;
        logic [7:0] dm;
        logic       pbit;
        eight = word_sel[2];
        pen   = !(word_sel == 3'b100 || word_sel == 3'b101);
        podd  = word_sel[0];
        two   = (word_sel == 3'b000 || word_sel == 3'b001 || word_sel == 3'b100);
        dm    = eight ? d : {1'b0, d[6:0]};
        pbit  = (^dm) ^ podd ^ bad_par;
        if (push) exp_q.push_back({dm, bad_stop, pen & bad_par});
        drive_bit(1'b0);
        for (int i = 0; i < (eight ? 8 : 7); i++) drive_bit(d[i]);
        if (pen) drive_bit(pbit);
        drive_bit(!bad_stop);
        if (two) drive_bit(1'b1);
        drive_bit(1'b1);
        repeat (8) @(negedge clk);
    endtask

    task automatic man_read();
        rd_man = 1'b1;
        @(negedge clk);
        rd_man = 1'b0;
        @(negedge clk);
    endtask

    // monitor: pops the scoreboard whenever a character shows up
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd && rx_full) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected character", {24'h0, rx_data}, 32'h0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e[9:2], {tag, " R3 data"}, {24'h0, rx_data}, {24'h0, e[9:2]});
                    chk(frame_err == e[1], {tag, " R6 frame_err"}, {31'h0, frame_err}, {31'h0, e[1]});
                    chk(par_err == e[0], {tag, " R7 par_err"}, {31'h0, par_err}, {31'h0, e[0]});
                end
                rd_auto = 1'b1;
                @(negedge clk);
                rd_auto = 1'b0;
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rx_full == 1'b0, "R1 rx_full", {31'h0, rx_full}, 32'h0);
        chk(overrun == 1'b0, "R1 overrun", {31'h0, overrun}, 32'h0);
        chk(frame_err == 1'b0 && par_err == 1'b0, "R1 error flags", {30'h0, frame_err, par_err}, 32'h0);
        chk(rx_data == 8'h00, "R1 rx_data", {24'h0, rx_data}, 32'h0);

        // R2 R3: every format at x1 rate
        auto_rd = 1'b1;
        div_sel = 2'b00;
        ndiv = 1;
        for (int w = 0; w < 8; w++) begin
            word_sel = w[2:0];
            tag = "R2";
            send_char(8'hA5 ^ (8'(w) * 8'h13), 1'b0, 1'b0, 1'b1);
            send_char(8'hC1, 1'b0, 1'b0, 1'b1);
        end
        chk(exp_q.size() == 0, "R2 all characters delivered", exp_q.size(), 32'h0);

        // R4: /16 and /64 rates
        tag = "R4";
        div_sel = 2'b01;
        ndiv = 16;
        word_sel = 3'b011;
        send_char(8'h55, 1'b0, 1'b0, 1'b1);
        send_char(8'h80, 1'b0, 1'b0, 1'b1);
        div_sel = 2'b10;
        ndiv = 64;
        word_sel = 3'b111;
        send_char(8'hC3, 1'b0, 1'b0, 1'b1);
        chk(exp_q.size() == 0, "R4 divided rates delivered", exp_q.size(), 32'h0);

        // R5: short low pulse at /16 is rejected
        div_sel = 2'b01;
        ndiv = 16;
        word_sel = 3'b101;
        rxd = 1'b0;
        repeat (3) rxc_cycle();
        rxd = 1'b1;
        repeat (40) rxc_cycle();
        chk(rx_full == 1'b0, "R5 glitch ignored", {31'h0, rx_full}, 32'h0);
        tag = "R5";
        send_char(8'h5A, 1'b0, 1'b0, 1'b1);

        // R6: framing error then a clean character
        tag = "R6";
        send_char(8'h0F, 1'b0, 1'b1, 1'b1);
        repeat (20) rxc_cycle();
        send_char(8'hF0, 1'b0, 1'b0, 1'b1);

        // R7: parity errors in even and odd formats, good parity too
        tag = "R7";
        word_sel = 3'b110;
        send_char(8'h37, 1'b1, 1'b0, 1'b1);
        word_sel = 3'b111;
        send_char(8'h37, 1'b1, 1'b0, 1'b1);
        send_char(8'h36, 1'b0, 1'b0, 1'b1);
        word_sel = 3'b010;
        send_char(8'h6B, 1'b1, 1'b0, 1'b1);
        chk(exp_q.size() == 0, "R7 error characters delivered", exp_q.size(), 32'h0);

        // R8: overrun sequencing
        auto_rd = 1'b0;
        repeat (4) @(negedge clk);
        word_sel = 3'b101;
        send_char(8'h11, 1'b0, 1'b0, 1'b0);
        send_char(8'h22, 1'b0, 1'b0, 1'b0);
        chk(rx_full == 1'b1, "R8 full before read", {31'h0, rx_full}, 32'h1);
        chk(overrun == 1'b0, "R8 overrun hidden", {31'h0, overrun}, 32'h0);
        chk(rx_data == 8'h11, "R8 first character kept", {24'h0, rx_data}, 32'h11);
        man_read();
        chk(overrun == 1'b1, "R8 overrun after first read", {31'h0, overrun}, 32'h1);
        chk(rx_full == 1'b1, "R8 full held during overrun", {31'h0, rx_full}, 32'h1);
        man_read();
        chk(rx_full == 1'b0 && overrun == 1'b0, "R8 second read clears",
            {30'h0, rx_full, overrun}, 32'h0);

        // R12: next character after overrun is intact
        tag = "R12";
        auto_rd = 1'b1;
        send_char(8'h96, 1'b0, 1'b0, 1'b1);
        chk(exp_q.size() == 0, "R12 post-overrun delivered", exp_q.size(), 32'h0);

        // R9 R10: carrier mask, then manual read
        auto_rd = 1'b0;
        repeat (4) @(negedge clk);
        send_char(8'h77, 1'b0, 1'b0, 1'b0);
        chk(rx_full == 1'b1, "R10 full before carrier loss", {31'h0, rx_full}, 32'h1);
        carrier_lost = 1'b1;
        @(negedge clk);
        chk(rx_full == 1'b0, "R10 masked while carrier lost", {31'h0, rx_full}, 32'h0);
        carrier_lost = 1'b0;
        @(negedge clk);
        chk(rx_full == 1'b1 && rx_data == 8'h77, "R10 state kept after carrier returns",
            {23'h0, rx_full, rx_data}, 32'h177);
        man_read();
        chk(rx_full == 1'b0, "R9 read clears full", {31'h0, rx_full}, 32'h0);

        // R11: master reset clears and ignores the line
        send_char(8'h99, 1'b0, 1'b0, 1'b0);
        chk(rx_full == 1'b1, "R11 full before master reset", {31'h0, rx_full}, 32'h1);
        div_sel = 2'b11;
        repeat (3) @(negedge clk);
        chk(rx_full == 1'b0 && rx_data == 8'h00, "R11 cleared by master reset",
            {23'h0, rx_full, rx_data}, 32'h0);
        send_char(8'h3C, 1'b0, 1'b0, 1'b0);
        chk(rx_full == 1'b0, "R11 line ignored in master reset", {31'h0, rx_full}, 32'h0);
        div_sel = 2'b01;
        repeat (4) @(negedge clk);
        tag = "R11";
        auto_rd = 1'b1;
        send_char(8'hE7, 1'b0, 1'b0, 1'b1);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R11 reception resumes", exp_q.size(), 32'h0);

        finish_run();
    end

endmodule